// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller

This block is the coherence engine for one small direct-mapped cache on a shared snooping bus. Every line holds a tag, one data word and a coherence state: invalid, shared or modified. A processor issues single-word reads and writes. Hits complete locally. Misses, and writes to shared lines, become bus transactions. Coherence is write-invalidate, and no update traffic is ever produced.

The controller issues one transaction at a time under a request/grant handshake. Memory ends each transaction with an acknowledge. At the same time the controller watches the transactions of the other caches. It answers each one in the same cycle with a presence signal. When it owns the line, it also drives the owned data so that the requester and memory both receive it.

The command for a pending access is derived again in every cycle from the current line state. An invalidation that arrives before the grant therefore changes a pending upgrade into a read-exclusive. A downgrade of a modified victim cancels the writeback that would otherwise be needed.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `bus_req` and `cpu_done` are low, and no snoop reports presence.
- R2: A read miss (victim not modified) requests command 0 (read) at the access address. After the acknowledge the line is shared, and `cpu_done` returns the data that memory supplied.
- R3: A read that hits a shared or modified line, and a write that hits a modified line, both complete with no bus request. `cpu_done` is a single-cycle pulse.
- R4: A write that hits a shared line first requests command 2 (upgrade) at the access address. After the acknowledge the line is modified and holds the written word.
- R5: A write miss (victim not modified) requests command 1 (read-exclusive). After the acknowledge the line is modified and holds the written word.
- R6: A snooped read (`snp_cmd` 0) that matches a shared line asserts `snp_shared`, does not assert `snp_flush`, and leaves the line shared.
- R7: A snooped read that matches a modified line asserts `snp_shared` and `snp_flush`, drives the line's word on `snp_data`, and downgrades the line to shared. A later local write then needs an upgrade.
- R8: A snooped read-exclusive (1) or upgrade (2) that matches a valid line invalidates that line. A modified line also flushes its word.
- R9: A miss whose victim is modified first requests command 3 (writeback). The request carries the victim's own address and word. After that acknowledge, the fill follows. A shared victim is dropped with no writeback.
- R10: If an invalidating snoop removes the line while an upgrade is waiting for grant, the request is reissued as a read-exclusive. A grant in a cycle with `snp_valid` high is ignored.
- R11: Only one transaction is in flight. Once granted, `bus_req` stays low until the acknowledge. While it waits for grant, the command, address and word stay stable unless a snoop intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Processor access request, one cycle, accepted when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Grant; the transaction starts in a cycle with `bus_req` and `bus_gnt` |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback word |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | DATA_W | Fill word, valid with `bus_ack` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Its command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Its address |
| snp_shared | output | 1 | This cache holds a valid copy (same cycle) |
| snp_flush | output | 1 | This cache owns the line and supplies it (same cycle) |
| snp_data | output | DATA_W | Supplied word |

## Verification
The bench builds the block with 6-bit addresses, 2 index bits and 16-bit words. This gives four lines, and four tags alias onto each line across the sixteen addresses the stimulus uses. Conflict evictions of shared and modified victims are therefore frequent. Random snoops often land on lines held in every state, and the read, read-exclusive, upgrade and writeback paths are all reached many times. The upgrade race and the downgrade-then-write orderings are forced with directed sequences.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_RDX = 2'd1,
    CMD_UPG = 2'd2,
    CMD_WB  = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_ACT  = 2'd1,
    F_WAIT = 2'd2
  } fsm_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  line_st_e          fill_st,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          snp_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_e [LINES-1:0]              st_vec;
  logic     [LINES-1:0][TAG_W-1:0]   tag_vec;
  logic     [LINES-1:0][DATA_W-1:0]  data_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              sel_fill, sel_snp;

    assign sel_fill = fill_en && (fill_idx == IDX_W'(i));
    assign sel_snp  = snp_en  && (snp_idx  == IDX_W'(i));

    // snoop update wins over a local update of the same line
    always_comb begin
      st_d = st_q;
      if (sel_fill) st_d = fill_st;
      if (sel_snp)  st_d = snp_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_I;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        tag_q  <= fill_tag;
        data_q <= fill_data;
      end
    end

    assign st_vec[i]   = st_q;
    assign tag_vec[i]  = tag_q;
    assign data_vec[i] = data_q;
  end

  assign a_st   = st_vec[a_idx];
  assign a_tag  = tag_vec[a_idx];
  assign a_data = data_vec[a_idx];
  assign b_st   = st_vec[b_idx];
  assign b_tag  = tag_vec[b_idx];
  assign b_data = data_vec[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_en,
  output line_st_e          upd_st
);
  bus_cmd_e cmd;
  logic     match;

  always_comb begin
    cmd    = bus_cmd_e'(snp_cmd);
    match  = snp_valid && (line_st != ST_I) &&
             (line_tag == snp_addr[ADDR_W-1:IDX_W]) && (cmd != CMD_WB);
    upd_st = line_st;
    flush_o = 1'b0;
    unique case (cmd)
      CMD_RD: begin
        flush_o = match && (line_st == ST_M);
        upd_st  = ST_S;
      end
      CMD_RDX, CMD_UPG: begin
        flush_o = match && (line_st == ST_M);
        upd_st  = ST_I;
      end
      default: upd_st = line_st;
    endcase
    shared_o = match;
    upd_en   = match && (upd_st != line_st);
    data_o   = line_data;
  end
endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [IDX_W-1:0]  line_idx,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              snp_busy,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              fill_en,
  output line_st_e          fill_st,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [DATA_W-1:0] fill_data
);
  fsm_e              fsm_q, fsm_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  bus_cmd_e          cmd_q;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [TAG_W-1:0]  req_tag;
  logic              hit, can_finish, finish, take, got_ack, accept;

  assign req_tag  = addr_q[ADDR_W-1:IDX_W];
  assign line_idx = addr_q[IDX_W-1:0];
  assign accept   = (fsm_q == F_IDLE) && cpu_req;

  always_comb begin
    hit        = (line_st != ST_I) && (line_tag == req_tag);
    can_finish = hit && (!we_q || (line_st == ST_M));
    // command chosen afresh each cycle from the live line state
    bus_addr = addr_q;
    if (hit) begin
      bus_cmd = CMD_UPG;
    end else if (line_st == ST_M) begin
      bus_cmd  = CMD_WB;
      bus_addr = {line_tag, line_idx};
    end else begin
      bus_cmd = we_q ? CMD_RDX : CMD_RD;
    end
    bus_wdata = line_data;
    bus_req   = (fsm_q == F_ACT) && !can_finish;
    finish    = (fsm_q == F_ACT) && can_finish && !snp_busy;
    take      = bus_req && bus_gnt && !snp_busy;
    got_ack   = (fsm_q == F_WAIT) && bus_ack;

    fill_en   = 1'b0;
    fill_st   = line_st;
    fill_tag  = line_tag;
    fill_data = line_data;
    if (finish && we_q) begin
      fill_en   = 1'b1;
      fill_st   = ST_M;
      fill_data = wdata_q;
    end
    if (got_ack) begin
      fill_en = 1'b1;
      unique case (cmd_q)
        CMD_WB:  fill_st = ST_I;
        CMD_RD: begin
          fill_st   = ST_S;
          fill_tag  = req_tag;
          fill_data = bus_rdata;
        end
        CMD_RDX: begin
          fill_st   = ST_M;
          fill_tag  = req_tag;
          fill_data = bus_rdata;
        end
        default: fill_st = ST_M;
      endcase
    end

    fsm_d = fsm_q;
    unique case (fsm_q)
      F_IDLE:  if (cpu_req) fsm_d = F_ACT;
      F_ACT: begin
        if (finish)    fsm_d = F_IDLE;
        else if (take) fsm_d = F_WAIT;
      end
      F_WAIT:  if (bus_ack) fsm_d = F_ACT;
      default: fsm_d = F_IDLE;
    endcase

    done_d  = finish;
    rdata_d = we_q ? wdata_q : line_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= F_IDLE;
      done_q <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      we_q    <= cpu_we;
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
    if (take)   cmd_q   <= bus_cmd;
    if (finish) rdata_q <= rdata_d;
  end

  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  line_st_e          a_st, b_st, fill_st, upd_st;
  logic [TAG_W-1:0]  a_tag, b_tag, fill_tag;
  logic [DATA_W-1:0] a_data, b_data, fill_data;
  logic              fill_en, upd_en;
  bus_cmd_e          cmd_w;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_idx     (a_idx),
    .a_st      (a_st),
    .a_tag     (a_tag),
    .a_data    (a_data),
    .b_idx     (snp_addr[IDX_W-1:0]),
    .b_st      (b_st),
    .b_tag     (b_tag),
    .b_data    (b_data),
    .fill_en   (fill_en),
    .fill_idx  (a_idx),
    .fill_st   (fill_st),
    .fill_tag  (fill_tag),
    .fill_data (fill_data),
    .snp_en    (upd_en),
    .snp_idx   (snp_addr[IDX_W-1:0]),
    .snp_st    (upd_st)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .line_st   (b_st),
    .line_tag  (b_tag),
    .line_data (b_data),
    .shared_o  (snp_shared),
    .flush_o   (snp_flush),
    .data_o    (snp_data),
    .upd_en    (upd_en),
    .upd_st    (upd_st)
  );

  msi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_done  (cpu_done),
    .cpu_rdata (cpu_rdata),
    .line_idx  (a_idx),
    .line_st   (a_st),
    .line_tag  (a_tag),
    .line_data (a_data),
    .snp_busy  (snp_valid),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (cmd_w),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .fill_en   (fill_en),
    .fill_st   (fill_st),
    .fill_tag  (fill_tag),
    .fill_data (fill_data)
  );

  assign bus_cmd = cmd_w;
endmodule

// File: rtl/msi_cache_chk.sv
module msi_cache_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              snp_valid,
  input logic              snp_shared,
  input logic              snp_flush
);
  // R1: quiet outputs while reset is applied
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!bus_req && !cpu_done)
        else $error("reset outputs not quiet");
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr) && $stable(bus_wdata)))
    else $error("request changed while waiting for grant");

  p_single_txn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid) |=> !bus_req)
    else $error("request still raised after grant");

  p_flush_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_shared)
    else $error("flush without presence");

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done)
    else $error("completion longer than one cycle");

  p_done_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req)
    else $error("bus request during completion");
endmodule

bind msi_cache_ctrl msi_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_done   (cpu_done),
  .bus_req    (bus_req),
  .bus_gnt    (bus_gnt),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .snp_valid  (snp_valid),
  .snp_shared (snp_shared),
  .snp_flush  (snp_flush)
);

// File: tb/sim_msi_cache_ctrl.sv
module sim_msi_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [5:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        bus_req, bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [1:0]  bus_cmd;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_cmd = '0;
  logic [5:0]  snp_addr = '0;
  logic        snp_shared, snp_flush;
  logic [15:0] snp_data;

  int checks = 0, errors = 0;
  int m_st[4];
  int m_tag[4];
  logic [15:0] m_dat[4];
  logic [15:0] mem[64];
  logic [15:0] gold[64];

  always #5 clk = ~clk;

  msi_cache_ctrl #(.ADDR_W(6), .IDX_W(2), .DATA_W(16)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string cmd_tag(input int c);
    case (c)
      0: return "R2";
      1: return "R5";
      2: return "R4";
      default: return "R9";
    endcase
  endfunction

  // called just after a falling edge; returns just after the next one
  task automatic snoop_now(input int cmd, input int a, input logic [15:0] nv);
    int ix = a % 4;
    bit match, eflush;
    string lbl;
    snp_valid = 1'b1; snp_cmd = cmd[1:0]; snp_addr = a[5:0];
    #1;
    match  = (m_st[ix] != 0) && (m_tag[ix] == a / 4) && (cmd != 3);
    eflush = match && (m_st[ix] == 2);
    lbl    = (cmd == 0) ? ((m_st[ix] == 2) ? "R7" : "R6") : "R8";
    chk(snp_shared == match, lbl, "snoop presence", int'(snp_shared), int'(match));
    chk(snp_flush == eflush, lbl, "snoop flush", int'(snp_flush), int'(eflush));
    if (eflush) begin
      chk(snp_data == gold[a], lbl, "flushed word", int'(snp_data), int'(gold[a]));
      mem[a] = snp_data;
    end
    if (match) m_st[ix] = (cmd == 0) ? 1 : 0;
    if (cmd == 1 || cmd == 2) begin
      gold[a] = nv;
      mem[a]  = nv;
    end
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic cpu_op(input bit we, input int a, input logic [15:0] wd, input bit race);
    int ix = a % 4, tg = a / 4;
    int cyc = 0, nbus = 0;
    bit raced = 1'b0;
    bit nobus;
    bit hit;
    int e_cmd, e_addr, c_cmd, c_addr, w;
    logic [15:0] c_wd;
    hit   = (m_st[ix] != 0) && (m_tag[ix] == tg);
    nobus = hit && (!we || m_st[ix] == 2);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a[5:0]; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    forever begin
      if (cpu_done) break;
      if (cyc > 100) begin
        chk(1'b0, "R11", "access never completed", cyc, 100);
        break;
      end
      cyc++;
      if (bus_req) begin
        hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
        e_addr = a;
        if (hit && !we) e_cmd = -1;
        else if (hit && m_st[ix] == 2) e_cmd = -1;
        else if (hit) e_cmd = 2;
        else if (m_st[ix] == 2) begin e_cmd = 3; e_addr = m_tag[ix] * 4 + ix; end
        else e_cmd = we ? 1 : 0;
        if (e_cmd < 0) begin
          chk(1'b0, "R3", "bus request on hit", int'(bus_cmd), e_cmd);
          @(negedge clk);
          continue;
        end
        chk(int'(bus_cmd) == e_cmd, raced ? "R10" : cmd_tag(e_cmd), "bus command",
            int'(bus_cmd), e_cmd);
        chk(int'(bus_addr) == e_addr, cmd_tag(e_cmd), "bus address", int'(bus_addr), e_addr);
        if (race && !raced && e_cmd == 2) begin
          raced = 1'b1;
          bus_gnt = 1'b1;  // grant offered under a snoop must be ignored (R10)
          snoop_now(1, a, 16'($urandom));
          bus_gnt = 1'b0;
          chk(bus_req == 1'b1, "R10", "request kept after ignored grant", int'(bus_req), 1);
          continue;
        end
        c_cmd = int'(bus_cmd); c_addr = int'(bus_addr); c_wd = bus_wdata;
        w = $urandom % 3;
        repeat (w) @(negedge clk);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(bus_req == 1'b0, "R11", "request dropped after grant", int'(bus_req), 0);
        w = $urandom % 3;
        repeat (w) @(negedge clk);
        bus_ack = 1'b1;
        bus_rdata = mem[c_addr];
        if (c_cmd == 3) begin
          chk(c_wd == gold[c_addr], "R9", "writeback word", int'(c_wd), int'(gold[c_addr]));
          mem[c_addr] = c_wd;
        end
        @(negedge clk);
        bus_ack = 1'b0;
        nbus++;
        case (c_cmd)
          0: begin m_st[ix] = 1; m_tag[ix] = tg; m_dat[ix] = mem[a]; end
          1: begin m_st[ix] = 2; m_tag[ix] = tg; m_dat[ix] = mem[a]; end
          2: m_st[ix] = 2;
          default: m_st[ix] = 0;
        endcase
      end else begin
        @(negedge clk);
      end
    end
    if (nobus) chk(nbus == 0, "R3", "bus transactions on hit", nbus, 0);
    if (!we) chk(cpu_rdata == gold[a], nobus ? "R3" : "R2", "read word",
                 int'(cpu_rdata), int'(gold[a]));
    else begin
      m_st[ix] = 2; m_tag[ix] = tg; m_dat[ix] = wd; gold[a] = wd;
    end
    @(negedge clk);
    chk(cpu_done == 1'b0, "R3", "completion pulse width", int'(cpu_done), 0);
  endtask

  task automatic snoop(input int cmd, input int a, input logic [15:0] nv);
    @(negedge clk);
    snoop_now(cmd, a, nv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0d5eed));
    for (int i = 0; i < 64; i++) begin
      mem[i]  = 16'(i * 37 + 5);
      gold[i] = mem[i];
    end
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = '0; end
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(bus_req == 1'b0, "R1", "bus_req after reset", int'(bus_req), 0);
    chk(cpu_done == 1'b0, "R1", "cpu_done after reset", int'(cpu_done), 0);
    snoop(0, 3, 16'h0);                 // R1: nothing present
    cpu_op(1'b0, 5, 16'h0, 1'b0);       // R2 read miss
    cpu_op(1'b0, 5, 16'h0, 1'b0);       // R3 read hit
    snoop(0, 5, 16'h0);                 // R6 shared stays
    cpu_op(1'b0, 5, 16'h0, 1'b0);       // R6 still a hit
    cpu_op(1'b1, 5, 16'hA5A5, 1'b0);    // R4 upgrade
    cpu_op(1'b1, 5, 16'h5A5A, 1'b0);    // R3 write hit on modified
    snoop(0, 5, 16'h0);                 // R7 flush + downgrade
    cpu_op(1'b1, 5, 16'h1234, 1'b0);    // R7 write needs upgrade again
    snoop(1, 5, 16'hBEEF);              // R8 invalidate with flush
    cpu_op(1'b0, 5, 16'h0, 1'b0);       // R8 read misses again
    cpu_op(1'b1, 9, 16'h0909, 1'b0);    // R9 shared victim silent, R5 write miss
    cpu_op(1'b0, 13, 16'h0, 1'b0);      // R9 modified victim written back
    cpu_op(1'b0, 2, 16'h0, 1'b0);
    cpu_op(1'b1, 2, 16'h2222, 1'b1);    // R10 lost upgrade race
    cpu_op(1'b0, 2, 16'h0, 1'b0);
    snoop(2, 13, 16'h7777);             // R8 upgrade snoop invalidates
    cpu_op(1'b0, 13, 16'h0, 1'b0);
    for (int n = 0; n < 600; n++) begin
      int a = $urandom % 16;
      int r = $urandom % 10;
      if (r < 6) cpu_op(($urandom % 2) == 1, a, 16'($urandom), ($urandom % 4) == 0);
      else begin
        int c = $urandom % 3;
        if (c == 2 && m_st[a % 4] == 2 && m_tag[a % 4] == a / 4) c = 1;
        snoop(c, a, 16'($urandom));
      end
    end
    for (int a = 0; a < 16; a++) cpu_op(1'b0, a, 16'h0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule